// File: doc/BRIEF.md
# Interleaved Five-Level T-Type Phase Modulator

This block generates the gate pattern for one output phase built from two three-level T-type legs joined through a coupling transformer. Each leg selects one of three switch states: high rail, neutral or low rail. The block picks that state by comparing a signed duty reference with a triangular carrier. Leg B's carrier runs half a period away from leg A's. Averaging the two leg voltages therefore gives five phase levels, and the ripple appears at twice the carrier frequency.

A control processor writes a signed reference and pulses an update strobe. The value waits in a shadow register and is copied to the active compare register only at a reload point. In single-reload mode the only reload point is the carrier valley. In dual-reload mode the carrier peak is a reload point as well, so a new reference takes effect within half a carrier period and the volt-seconds on each transformer winding stay balanced. A carrier-placement select chooses where the low-band carrier sits: in phase with the high-band carrier (phase disposition) or mirrored against it (phase opposition).

Top module: `tlev_pwm_phase`

## Requirements
- R1: Each leg's gate nibble is {T1,T2,T3,T4} with T1 in bit 3 and T4 in bit 0. It only ever takes one of three codes: high 4'b1100, neutral 4'b0110, low 4'b0011.
- R2: While rst_n is low at a clock edge, both legs go to neutral (4'b0110), the phase level reads 2, and the carrier restarts at zero.
- R3: The leg A carrier c counts 0,1,...,PERIOD,PERIOD-1,...,1 and then repeats, so one period is 2*PERIOD cycles. The leg B carrier is PERIOD-c.
- R4: When the active reference r is positive, a leg is high if r > its carrier and neutral otherwise. It never goes low.
- R5: When r is negative, a leg is low if r < the low-band carrier and neutral otherwise. The low-band carrier is c-PERIOD when pod_sel=0 and -c when pod_sel=1.
- R6: upd_stb captures ref_in into a shadow register. The gates keep using the previous active value until the next reload point.
- R7: With dual_upd=1 the active value reloads at both the carrier valley and the carrier peak. With dual_upd=0 it reloads only at the valley. A reload at the edge where the carrier sits at that point first shows in the gates one edge later.
- R8: The level output is the sum of the two leg states, counting low=0, neutral=1, high=2. This gives 4 for high/high, 3 for high/neutral, 2 for neutral/neutral or high/low, 1 for neutral/low and 0 for low/low.
- R9: With a constant reference, leg B's gate sequence equals leg A's delayed by PERIOD cycles.
- R10: With a constant reference r where 1 <= |r| <= PERIOD, each leg spends 2*|r|-1 cycles of every carrier period in the active rail state. With r=0 it spends none.
- R11: Gate outputs are registered. The state seen after an edge comes from the carrier value and the active reference present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | REF_W | Signed duty reference, magnitude up to PERIOD |
| upd_stb | input | 1 | Captures ref_in into the shadow register |
| pod_sel | input | 1 | 0 = phase disposition, 1 = phase opposition carrier placement |
| dual_upd | input | 1 | 1 = reload at valley and peak, 0 = valley only |
| gate_a | output | 4 | Leg A gates {T1,T2,T3,T4} |
| gate_b | output | 4 | Leg B gates {T1,T2,T3,T4} |
| level | output | 3 | Present phase level, 0 to 4 |

## Verification
The bench sweeps every reference from -PERIOD to +PERIOD under both carrier placements and predicts each gate state for each cycle from the triangle arithmetic. The smallest negative references separate the two placements. At r=-1, phase disposition pulses low only at the carrier peak and phase opposition only at the valley, so a design with the placements swapped puts its low pulse half a period off. A half-period leg B shift with the wrong sign, or an off-by-one in the triangle turnaround, breaks the mirror check and the per-period duty count. The reload test sends a new reference in mid-rise. A design that reloads at the wrong point, or copies the strobe straight to the compare value, switches the gates at the wrong edge.

// File: rtl/tlev_pkg.sv
// Package tlev_pkg
// Shared leg-state type plus gate and level encoders for the five-level
// phase modulator. Assumes legal states only; anything else maps to neutral.
package tlev_pkg;

    typedef enum logic [1:0] {
        LEG_N = 2'd0,
        LEG_O = 2'd1,
        LEG_P = 2'd2
    } leg_state_e;

    localparam logic [3:0] GATE_P = 4'b1100;
    localparam logic [3:0] GATE_O = 4'b0110;
    localparam logic [3:0] GATE_N = 4'b0011;

    // Map a leg state to its {T1,T2,T3,T4} pattern.
    function automatic logic [3:0] gate_code(leg_state_e s);
        case (s)
            LEG_P:   return GATE_P;
            LEG_N:   return GATE_N;
            default: return GATE_O;
        endcase
    endfunction

    // Phase level is the sum of the two leg weights (N=0, O=1, P=2).
    function automatic logic [2:0] phase_level(leg_state_e a, leg_state_e b);
        logic [2:0] wa;
        logic [2:0] wb;
        wa = {1'b0, a};
        wb = {1'b0, b};
        return wa + wb;
    endfunction

endpackage

// File: rtl/tlev_carrier.sv
// Module tlev_carrier
// Up/down triangle counter 0..PERIOD..1 (period 2*PERIOD cycles) for leg A
// and its half-period-shifted twin PERIOD-c for leg B. Valley and peak
// flags are single-cycle decodes of the count. Assumes PERIOD >= 2.
module tlev_carrier #(
    parameter int PERIOD = 1000,
    parameter int CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_a,
    output logic [CNT_W-1:0] cnt_b,
    output logic             at_valley,
    output logic             at_peak
);

    localparam logic [CNT_W-1:0] TOP     = CNT_W'(PERIOD);
    localparam logic [CNT_W-1:0] LAST_UP = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic going_up;

    // Advance the triangle and turn at the peak and the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_a    <= '0;
            going_up <= 1'b1;
        end else if (going_up) begin
            if (cnt_a == LAST_UP) going_up <= 1'b0;
            cnt_a <= cnt_a + ONE;
        end else begin
            if (cnt_a == ONE) going_up <= 1'b1;
            cnt_a <= cnt_a - ONE;
        end
    end

    // Leg B carrier is the mirror image, i.e. half a period later.
    always_comb cnt_b = TOP - cnt_a;

    // Reload-point decodes.
    always_comb begin
        at_valley = (cnt_a == '0);
        at_peak   = (cnt_a == TOP);
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_a <= TOP);
    p_peak_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_peak |=> (cnt_a == LAST_UP));
    p_valley_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_valley |=> (cnt_a == ONE));
    p_peak_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        at_peak |=> !at_peak);

endmodule

// File: rtl/tlev_cmp_reg.sv
// Module tlev_cmp_reg
// Shadow/active compare register pair. The strobe writes the shadow. The
// active value takes the shadow at the valley, and also at the peak when
// dual reload is selected. Assumes the strobe is synchronous to clk.
module tlev_cmp_reg #(
    parameter int REF_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic                    upd_stb,
    input  logic                    at_valley,
    input  logic                    at_peak,
    input  logic                    dual_upd,
    output logic signed [REF_W-1:0] active
);

    logic signed [REF_W-1:0] shadow;
    logic                    reload;

    // Permitted reload points for the active compare value.
    always_comb reload = at_valley | (at_peak & dual_upd);

    // Capture the newest reference from the controller.
    always_ff @(posedge clk) begin
        if (!rst_n)       shadow <= '0;
        else if (upd_stb) shadow <= ref_in;
    end

    // Move the shadow into the active register at a reload point only.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= '0;
        else if (reload) active <= shadow;
    end

    p_hold_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_valley || (at_peak && dual_upd)) |=> $stable(active));
    p_peak_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_peak && dual_upd) |=> (active == $past(shadow)));
    p_single_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (at_peak && !dual_upd) |=> $stable(active));

endmodule

// File: rtl/tlev_leg.sv
// Module tlev_leg
// One three-level leg: compares the active reference with the high-band
// carrier and the selected low-band carrier, and registers the state.
// Assumes |active| <= PERIOD; larger magnitudes simply saturate.
module tlev_leg
    import tlev_pkg::*;
#(
    parameter int PERIOD = 1000,
    parameter int CNT_W  = $clog2(PERIOD + 1),
    parameter int REF_W  = CNT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        carrier,
    input  logic signed [REF_W-1:0] active,
    input  logic                    pod_sel,
    output leg_state_e              state,
    output logic [3:0]              gate
);

    localparam logic signed [REF_W-1:0] PER_S = REF_W'(PERIOD);

    logic signed [REF_W-1:0] up_c;
    logic signed [REF_W-1:0] lo_c;
    leg_state_e              state_nxt;

    // Build signed high-band and low-band carriers.
    always_comb begin
        up_c = $signed({{(REF_W - CNT_W){1'b0}}, carrier});
        lo_c = pod_sel ? -up_c : (up_c - PER_S);
    end

    // Pick the rail: high above the high band, low below the low band.
    always_comb begin
        if (active > up_c)      state_nxt = LEG_P;
        else if (active < lo_c) state_nxt = LEG_N;
        else                    state_nxt = LEG_O;
    end

    // Register the leg state; reset parks the leg at neutral.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LEG_O;
        else        state <= state_nxt;
    end

    always_comb gate = gate_code(state);

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate == GATE_P) || (gate == GATE_O) || (gate == GATE_N));
    p_upper_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) >= 0) |-> (state != LEG_N));
    p_lower_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) <= 0) |-> (state != LEG_P));

endmodule

// File: rtl/tlev_pwm_phase.sv
// Module tlev_pwm_phase
// Top of the interleaved five-level phase modulator: one carrier pair, one
// shadow/active compare register and two legs built by a generate loop.
// Assumes PERIOD >= 2 and a reference magnitude within PERIOD.
module tlev_pwm_phase
    import tlev_pkg::*;
#(
    parameter int  PERIOD = 1000,
    localparam int CNT_W  = $clog2(PERIOD + 1),
    localparam int REF_W  = CNT_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_in,
    input  logic                    upd_stb,
    input  logic                    pod_sel,
    input  logic                    dual_upd,
    output logic [3:0]              gate_a,
    output logic [3:0]              gate_b,
    output logic [2:0]              level
);

    localparam int N_LEGS = 2;

    logic [CNT_W-1:0]        cnt_a;
    logic [CNT_W-1:0]        cnt_b;
    logic                    at_valley;
    logic                    at_peak;
    logic signed [REF_W-1:0] active;
    logic [CNT_W-1:0]        leg_car  [N_LEGS];
    leg_state_e              leg_st   [N_LEGS];
    logic [3:0]              leg_gate [N_LEGS];

    tlev_carrier #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_a     (cnt_a),
        .cnt_b     (cnt_b),
        .at_valley (at_valley),
        .at_peak   (at_peak)
    );

    tlev_cmp_reg #(.REF_W(REF_W)) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .upd_stb   (upd_stb),
        .at_valley (at_valley),
        .at_peak   (at_peak),
        .dual_upd  (dual_upd),
        .active    (active)
    );

    // Route each leg's carrier: leg 0 on the base, leg 1 on the mirror.
    always_comb begin
        leg_car[0] = cnt_a;
        leg_car[1] = cnt_b;
    end

    for (genvar g = 0; g < N_LEGS; g++) begin : g_leg
        tlev_leg #(.PERIOD(PERIOD), .CNT_W(CNT_W), .REF_W(REF_W)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .carrier (leg_car[g]),
            .active  (active),
            .pod_sel (pod_sel),
            .state   (leg_st[g]),
            .gate    (leg_gate[g])
        );
    end

    // Drive the outputs from the registered leg states.
    always_comb begin
        gate_a = leg_gate[0];
        gate_b = leg_gate[1];
        level  = phase_level(leg_st[0], leg_st[1]);
    end

    p_reset_idle_r2: assert property (@(posedge clk)
        !rst_n |=> (gate_a == GATE_O) && (gate_b == GATE_O) && (level == 3'd2));
    p_level_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 3'd4) |-> (gate_a == GATE_P) && (gate_b == GATE_P));
    p_level_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 3'd0) |-> (gate_a == GATE_N) && (gate_b == GATE_N));
    p_level_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        level <= 3'd4);

endmodule

// File: tb/tlev_pwm_phase_bench.sv
// Bench for tlev_pwm_phase with a short carrier: it sweeps every reference
// under both placements and checks the reload timing in both update modes.
module tlev_pwm_phase_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PER        = 6;
    localparam int CW         = $clog2(PER + 1);
    localparam int RW         = CW + 2;
    localparam int TP         = 2 * PER;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [RW-1:0] ref_in = '0;
    logic                 upd_stb = 1'b0;
    logic                 pod_sel = 1'b0;
    logic                 dual_upd = 1'b1;
    logic [3:0]           gate_a;
    logic [3:0]           gate_b;
    logic [2:0]           level;

    int n_chk  = 0;
    int n_fail = 0;
    int ne     = 0;
    logic [3:0] ga_hist [64];
    logic [3:0] gb_hist [64];

    tlev_pwm_phase #(.PERIOD(PER)) u_tlev_pwm_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .upd_stb  (upd_stb),
        .pod_sel  (pod_sel),
        .dual_upd (dual_upd),
        .gate_a   (gate_a),
        .gate_b   (gate_b),
        .level    (level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Count edges since reset release (after edge k, ne == k+1).
    always @(posedge clk) begin
        if (!rst_n) ne <= 0;
        else        ne <= ne + 1;
    end

    function automatic int tri_c(int k);
        int m;
        m = k % TP;
        return (m <= PER) ? m : TP - m;
    endfunction

    // Leg state from the requirements: 2 = high, 1 = neutral, 0 = low.
    function automatic int exp_state(int r, int c, int pod);
        int lo;
        lo = pod ? -c : c - PER;
        if (r > c)  return 2;
        if (r < lo) return 0;
        return 1;
    endfunction

    function automatic logic [3:0] exp_gate(int s);
        if (s == 2) return 4'b1100;
        if (s == 0) return 4'b0011;
        return 4'b0110;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_edge(input int k);
        while (ne < k + 1) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        upd_stb = 1'b0;
        repeat (3) @(negedge clk);
        check(gate_a == 4'b0110, "R2 gate_a", gate_a, 4'b0110);
        check(gate_b == 4'b0110, "R2 gate_b", gate_b, 4'b0110);
        check(level == 3'd2, "R2 level", level, 2);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input int r);
        ref_in  = RW'(r);
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
    endtask

    // Constant reference: per-cycle gates and level, duty count, mirror.
    task automatic run_ref(input int r, input int pod);
        int sa, sb, cnt_on;
        pod_sel  = pod[0];
        dual_upd = 1'b1;
        do_reset();
        strobe(r);
        cnt_on = 0;
        for (int k = 4 * PER; k < 6 * PER; k++) begin
            wait_edge(k);
            sa = exp_state(r, tri_c(k), pod);
            sb = exp_state(r, PER - tri_c(k), pod);
            check(gate_a == exp_gate(sa), pod ? "R5 R11 gate_a pod" : "R4 R11 gate_a pd",
                  gate_a, exp_gate(sa));
            check(gate_b == exp_gate(sb), "R3 R4 R5 gate_b", gate_b, exp_gate(sb));
            check(level == 3'(sa + sb), "R8 level", level, sa + sb);
            check((gate_a == 4'b1100) || (gate_a == 4'b0110) || (gate_a == 4'b0011),
                  "R1 legal", gate_a, 4'b0110);
            ga_hist[k - 4 * PER] = gate_a;
            gb_hist[k - 4 * PER] = gate_b;
            if (r > 0 && gate_a == 4'b1100) cnt_on++;
            if (r < 0 && gate_a == 4'b0011) cnt_on++;
            if (r == 0 && gate_a != 4'b0110) cnt_on++;
        end
        check(cnt_on == ((r == 0) ? 0 : 2 * ((r < 0) ? -r : r) - 1), "R10 duty",
              cnt_on, (r == 0) ? 0 : 2 * ((r < 0) ? -r : r) - 1);
        for (int i = 0; i < PER; i++)
            check(gb_hist[i] == ga_hist[i + PER], "R9 mirror", gb_hist[i], ga_hist[i + PER]);
    endtask

    // New reference mid-rise: switch edge depends on the reload mode.
    task automatic run_reload(input int dual);
        int r0, r1, sw, rr, s;
        r0 = 2;
        r1 = -3;
        pod_sel  = 1'b0;
        dual_upd = dual[0];
        do_reset();
        strobe(r0);
        wait_edge(8 * PER);
        strobe(r1);
        sw = dual ? 9 * PER : 10 * PER;
        for (int k = 8 * PER + 2; k <= 11 * PER; k++) begin
            wait_edge(k);
            rr = (k <= sw) ? r0 : r1;
            s  = exp_state(rr, tri_c(k), 0);
            check(gate_a == exp_gate(s), dual ? "R7 dual reload" : "R6 R7 single reload",
                  gate_a, exp_gate(s));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int pod = 0; pod < 2; pod++)
            for (int r = -PER; r <= PER; r++)
                run_ref(r, pod);
        run_reload(1);
        run_reload(0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule